// File: doc/BRIEF.md
# Software Interrupt Request Dispatcher

This block sits behind one write-only register of an interrupt distributor. A CPU writes a single 32-bit request word to it; the block decodes from that word an interrupt number in the range 0 to 15, a list of candidate CPUs and a filter mode. It then resolves the final recipient set against the CPU that made the request and the number of CPUs currently online.

For every recipient the block raises a one-cycle set strobe for the chosen interrupt. It also presents a one-hot source vector that names the requester, so each recipient can OR that bit into its per-interrupt sender mask. The strobes are combinational from the write and are present only while the write is presented. Reads of the register always return zero.

Top module: `sgi_dispatch`

## Requirements
- R1: A request is taken only when `wr_en` is high, all four bits of `wr_strb` are set and `wr_addr_lo` is 0; any other access produces no strobe.
- R2: The interrupt number is `wr_data[3:0]`, the candidate list is `wr_data[23:16]` (bit n names CPU n) and the mode is `wr_data[25:24]`; all other data bits have no effect.
- R3: Mode 0 delivers to the CPUs in the candidate list, restricted to online CPUs.
- R4: Mode 1 delivers to every online CPU except the requester, whatever the candidate list holds.
- R5: Mode 2 delivers to the requester alone.
- R6: Mode 3 is reserved; such a write raises no strobe.
- R7: For each recipient c, bit `c*16 + id` of `set_pend` is high in the same cycle as the accepted write. No other bit of `set_pend` is high, and nothing remains high once `wr_en` falls.
- R8: `set_src` is the one-hot code of `req_cpu` whenever any strobe is raised, and zero otherwise.
- R9: `rd_data` is zero at all times, including during writes.
- R10: CPU n counts as online when n < `cpus_online`. A count above `MAX_CPUS` means all CPUs are online; a count of 0 means none are, and nothing is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, used by the embedded checks |
| wr_en | input | 1 | Write access to the request register |
| wr_strb | input | 4 | Byte enables of the write |
| wr_addr_lo | input | 2 | Low address bits of the access |
| wr_data | input | 32 | Request word |
| req_cpu | input | 3 | Index of the requesting CPU |
| cpus_online | input | 4 | Number of CPUs online |
| set_pend | output | 128 | Set strobes, CPU-major, 16 per CPU |
| set_src | output | 8 | One-hot requester, for the recipients' sender masks |
| rd_data | output | 32 | Read value of the register |

## Verification
The bench builds the block with its defaults: eight CPUs and sixteen interrupts. With these values the full 8-bit candidate list is used, so a list entry past the online count can be shown to be dropped. The 4-bit count port can carry values above eight, which exercises the clamp, and also zero. Requesters at index 0 and index 7 both appear, so the "all but self" mode is exercised at both ends of the mask.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int WORD_W   = 32;
   localparam int ID_LSB   = 0;
   localparam int ID_W     = 4;
   localparam int LIST_LSB = 16;
   localparam int LIST_W   = 8;
   localparam int MODE_LSB = 24;

   typedef enum logic [1:0] {
      TGT_LIST   = 2'd0,
      TGT_OTHERS = 2'd1,
      TGT_SELF   = 2'd2,
      TGT_RSVD   = 2'd3
   } tgt_mode_e;
endpackage

// File: rtl/sgi_word_decode.sv
module sgi_word_decode
   import sgi_pkg::*;
(
   input  logic              wr_en,
   input  logic [3:0]        wr_strb,
   input  logic [1:0]        wr_addr_lo,
   input  logic [WORD_W-1:0] wr_data,
   output logic              fire,
   output tgt_mode_e         mode,
   output logic [LIST_W-1:0] list,
   output logic [ID_W-1:0]   id
);
   logic full_word;

   assign full_word = (wr_strb == 4'hF) && (wr_addr_lo == 2'd0);
   assign mode      = tgt_mode_e'(wr_data[MODE_LSB +: 2]);
   assign list      = wr_data[LIST_LSB +: LIST_W];
   assign id        = wr_data[ID_LSB +: ID_W];
   assign fire      = wr_en && full_word && (mode != TGT_RSVD);
endmodule

// File: rtl/sgi_target_resolve.sv
module sgi_target_resolve
   import sgi_pkg::*;
#(
   parameter int MAX_CPUS = 8,
   localparam int CPU_W = $clog2(MAX_CPUS),
   localparam int CNT_W = $clog2(MAX_CPUS + 1)
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  tgt_mode_e           mode,
   input  logic [LIST_W-1:0]   list,
   input  logic [CPU_W-1:0]    req_cpu,
   input  logic [CNT_W-1:0]    cpus_online,
   output logic [MAX_CPUS-1:0] tgt
);
   logic [MAX_CPUS-1:0] online;
   logic [MAX_CPUS-1:0] self_oh;
   logic [MAX_CPUS-1:0] chosen;

   for (genvar c = 0; c < MAX_CPUS; c++) begin : g_cpu
      assign online[c]  = (cpus_online > CNT_W'(c));
      assign self_oh[c] = (req_cpu == CPU_W'(c));
   end

   always_comb begin
      unique case (mode)
         TGT_LIST:   chosen = list[MAX_CPUS-1:0];
         TGT_OTHERS: chosen = ~self_oh;
         TGT_SELF:   chosen = self_oh;
         default:    chosen = '0;
      endcase
   end

   assign tgt = fire ? (chosen & online) : '0;

   // R10
   offline_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt & ~online) == '0);
   // R3
   list_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == TGT_LIST) |-> ((tgt & ~list[MAX_CPUS-1:0]) == '0));
   // R4
   others_skip_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == TGT_OTHERS) |-> !tgt[req_cpu]);
   // R5
   self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode == TGT_SELF) |-> $onehot0(tgt));
endmodule

// File: rtl/sgi_strobe_expand.sv
module sgi_strobe_expand
#(
   parameter int MAX_CPUS = 8,
   parameter int NUM_SGI  = 16,
   localparam int ID_W = $clog2(NUM_SGI)
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [MAX_CPUS-1:0]         tgt,
   input  logic [ID_W-1:0]             id,
   output logic [MAX_CPUS*NUM_SGI-1:0] pend
);
   for (genvar c = 0; c < MAX_CPUS; c++) begin : g_row
      for (genvar s = 0; s < NUM_SGI; s++) begin : g_col
         assign pend[c*NUM_SGI + s] = tgt[c] && (id == ID_W'(s));
      end
   end

   // R7
   one_per_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pend) == $countones(tgt));
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int MAX_CPUS = 8,
   parameter int NUM_SGI  = 16,
   localparam int CPU_W = $clog2(MAX_CPUS),
   localparam int CNT_W = $clog2(MAX_CPUS + 1),
   localparam int PEND_W = MAX_CPUS * NUM_SGI
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_strb,
   input  logic [1:0]          wr_addr_lo,
   input  logic [WORD_W-1:0]   wr_data,
   input  logic [CPU_W-1:0]    req_cpu,
   input  logic [CNT_W-1:0]    cpus_online,
   output logic [PEND_W-1:0]   set_pend,
   output logic [MAX_CPUS-1:0] set_src,
   output logic [WORD_W-1:0]   rd_data
);
   if (MAX_CPUS < 2 || MAX_CPUS > LIST_W) begin : g_bad_cpus
      $error("MAX_CPUS must lie in 2..8");
   end
   if (NUM_SGI != (1 << ID_W)) begin : g_bad_sgi
      $error("NUM_SGI must match the id field width");
   end

   logic                fire;
   tgt_mode_e           mode;
   logic [LIST_W-1:0]   list;
   logic [ID_W-1:0]     id;
   logic [MAX_CPUS-1:0] tgt;
   logic                unused_bits;

   assign unused_bits = ^{wr_data[WORD_W-1:MODE_LSB+2], wr_data[LIST_LSB-1:ID_W]};

   sgi_word_decode u_dec (
      .wr_en(wr_en), .wr_strb(wr_strb), .wr_addr_lo(wr_addr_lo),
      .wr_data(wr_data), .fire(fire), .mode(mode), .list(list), .id(id)
   );

   sgi_target_resolve #(.MAX_CPUS(MAX_CPUS)) u_res (
      .clk(clk), .rst_n(rst_n), .fire(fire), .mode(mode), .list(list),
      .req_cpu(req_cpu), .cpus_online(cpus_online), .tgt(tgt)
   );

   sgi_strobe_expand #(.MAX_CPUS(MAX_CPUS), .NUM_SGI(NUM_SGI)) u_exp (
      .clk(clk), .rst_n(rst_n), .tgt(tgt), .id(id), .pend(set_pend)
   );

   for (genvar c = 0; c < MAX_CPUS; c++) begin : g_src
      assign set_src[c] = (|tgt) && (req_cpu == CPU_W'(c));
   end

   assign rd_data = '0;

   // R6
   reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data[MODE_LSB +: 2] == 2'd3) |-> (set_pend == '0));
   // R1
   partial_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_strb != 4'hF || wr_addr_lo != 2'd0) |-> (set_pend == '0));
   // R8
   src_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pend != '0) |-> $onehot(set_src));
endmodule

// File: tb/sgi_dispatch_bench.sv
module sgi_dispatch_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [3:0]   wr_strb = 4'h0;
   logic [1:0]   wr_addr_lo = 2'd0;
   logic [31:0]  wr_data = '0;
   logic [2:0]   req_cpu = '0;
   logic [3:0]   cpus_online = 4'd8;
   logic [127:0] set_pend;
   logic [7:0]   set_src;
   logic [31:0]  rd_data;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sgi_dispatch u_sgi_dispatch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
      .wr_addr_lo(wr_addr_lo), .wr_data(wr_data), .req_cpu(req_cpu),
      .cpus_online(cpus_online), .set_pend(set_pend), .set_src(set_src),
      .rd_data(rd_data)
   );

   // {cpus_online, req_cpu, wr_data, expected recipients}
   localparam logic [46:0] VEC [NV] = '{
      {4'd8,  3'd0, 32'h00A5_0003, 8'hA5},  // R3 plain list
      {4'd4,  3'd1, 32'h00FF_000F, 8'h0F},  // R3 R10 list trimmed to online
      {4'd8,  3'd2, 32'hFD12_ABC7, 8'hFB},  // R4 R2 junk bits, list ignored
      {4'd3,  3'd0, 32'h0100_0000, 8'h06},  // R4 requester at 0
      {4'd5,  3'd4, 32'h0200_0009, 8'h10},  // R5 self only
      {4'd8,  3'd6, 32'h03FF_0002, 8'h00},  // R6 reserved
      {4'd1,  3'd0, 32'h01FF_0001, 8'h00},  // R4 single CPU, nobody else
      {4'd12, 3'd7, 32'h0100_0004, 8'h7F},  // R10 clamp, requester at 7
      {4'd0,  3'd0, 32'h00FF_0001, 8'h00},  // R10 none online
      {4'd8,  3'd3, 32'h0000_0005, 8'h00},  // R3 empty list
      {4'd8,  3'd5, 32'hF0C3_5A5E, 8'hC3}   // R2 junk bits in mode 0
   };

   function automatic logic [127:0] expand(input logic [7:0] t, input logic [3:0] id);
      logic [127:0] r = '0;
      for (int c = 0; c < 8; c++) if (t[c]) r[c*16 + id] = 1'b1;
      return r;
   endfunction

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic quiet(input string req);
      chk(req, set_pend, '0);
      chk(req, {120'd0, set_src}, '0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 5000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state: no write, nothing raised (R7 R8 R9)
      quiet("R7");
      chk("R9", {96'd0, rd_data}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         cpus_online = VEC[i][46:43];
         req_cpu     = VEC[i][42:40];
         wr_data     = VEC[i][39:8];
         wr_strb     = 4'hF;
         wr_addr_lo  = 2'd0;
         wr_en       = 1'b1;
         #1;
         chk("R7", set_pend, expand(VEC[i][7:0], VEC[i][11:8]));
         chk("R8", {120'd0, set_src},
             {120'd0, (VEC[i][7:0] != 0) ? (8'd1 << VEC[i][42:40]) : 8'd0});
         chk("R9", {96'd0, rd_data}, '0);
         @(negedge clk);
         wr_en = 1'b0;
         #1;
         quiet("R7");   // strobe gone once write ends
         @(negedge clk);
      end

      // R1: partial byte enables dropped
      cpus_online = 4'd8; req_cpu = 3'd1; wr_data = 32'h00FF_0006;
      wr_strb = 4'h3; wr_en = 1'b1;
      #1; quiet("R1");
      @(negedge clk);
      // R1: misaligned address dropped
      wr_strb = 4'hF; wr_addr_lo = 2'd2;
      #1; quiet("R1");
      @(negedge clk);
      // R1 R7: same word aligned now goes through
      wr_addr_lo = 2'd0;
      #1; chk("R1", set_pend, expand(8'hFF, 4'd6));
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule